// File: doc/BRIEF.md
# Floating-Point to 32-bit Integer Converter

This block takes one IEEE-754 binary floating-point operand, single or double precision, and produces a 32-bit integer. The integer can be signed or unsigned. A per-operation rounding mode picks one of four rules: nearest with ties away from zero, nearest with ties to even, toward plus infinity, or toward minus infinity. Values outside the target range are clamped to the nearest limit. A NaN operand gives zero.

Each operation is presented for one clock cycle with `in_valid` high. The operand is unpacked into sign, exponent and significand. It is aligned against a fixed binary point so that the integer part, a guard bit and a sticky bit come out together. The chosen mode then sets a one-bit increment. The result is clamped to the target range and captured in an output register. Operations can arrive on back-to-back cycles. The result register loads only on valid cycles and keeps its value otherwise.

Top module: `fp2int_conv`

## Requirements
- R1: With `in_rmode` = 2'b00 the value rounds to the nearest integer. A fraction of exactly one half moves the result away from zero, so -0.5 gives -1 and 2.5 gives 3.
- R2: With `in_rmode` = 2'b01 the value rounds to the nearest integer. A fraction of exactly one half goes to the even neighbour, so 2.5 gives 2, 3.5 gives 4 and -0.5 gives 0.
- R3: With `in_rmode` = 2'b10 the result is the ceiling of the value. Any positive value below one, including a subnormal, gives 1.
- R4: With `in_rmode` = 2'b11 the result is the floor of the value. Any negative value above -1 gives -1 when the result is signed.
- R5: With `in_dbl` = 0 the operand is the single-precision value in `in_op[31:0]`, and `in_op[63:32]` has no effect on the result. With `in_dbl` = 1 all 64 bits form a double-precision value.
- R6: With `in_signed` = 1 the rounded value is returned in two's complement. A rounded value of 2^31-1 or more gives 32'h7FFFFFFF, and a rounded value below -2^31 gives 32'h80000000.
- R7: With `in_signed` = 0 the rounded value is returned as an unsigned integer. A rounded value of 2^32-1 or more gives 32'hFFFFFFFF, and any negative rounded value gives 0.
- R8: A NaN operand, quiet or signalling, of either sign and either precision gives 0 in every mode and for both signedness settings.
- R9: Plus infinity gives 32'h7FFFFFFF when signed and 32'hFFFFFFFF when unsigned. Minus infinity gives 32'h80000000 when signed and 0 when unsigned.
- R10: Zero of either sign gives 0. A negative value that rounds to zero gives 0, never a wrapped or negative pattern.
- R11: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise, and it is low while `rst_n` is asserted.
- R12: `out_result` keeps its last value across cycles in which `in_valid` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Operand; single precision occupies bits 31:0 |
| in_dbl | input | 1 | 0 = single precision, 1 = double precision |
| in_signed | input | 1 | 0 = unsigned result, 1 = signed result |
| in_rmode | input | 2 | 00 ties away, 01 ties even, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_result | output | 32 | Converted integer |

## Verification
The only state is the output register and its valid flag. Every other fault is a combinational path error, and it shows up in `out_result` exactly one cycle after the operand that triggers it. A wrong shift amount or guard/sticky extraction affects only particular fractions. A wrong increment condition affects only particular modes and signs. A wrong clamp affects only values near the range limits. For this reason the quarter-step sweep runs over every mode, both precisions and both signedness settings, and it is backed by explicit limit values. A broken load enable shows up in the first idle cycle after a result, as a changed `out_result` while `out_valid` is low.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int OP_W   = 64;   // operand bus width
  localparam int INT_W  = 32;   // integer result width
  localparam int MAN_W  = 53;   // aligned significand width (hidden bit included)
  localparam int EXP_W  = 13;   // signed unbiased exponent width

  localparam int SGL_EW = 8;
  localparam int SGL_FW = 23;
  localparam int DBL_EW = 11;
  localparam int DBL_FW = 52;

  typedef enum logic [1:0] {
    RM_TIES_AWAY = 2'b00,
    RM_TIES_EVEN = 2'b01,
    RM_UP        = 2'b10,
    RM_DOWN      = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic                    is_zero;
    logic                    is_sub;
    logic signed [EXP_W-1:0] exp;
    logic [MAN_W-1:0]        mant;
  } fpc_unp_t;

endpackage

// File: rtl/fpc_field_dec.sv
// Decodes one IEEE-754 format into sign, class, unbiased exponent and a
// left-aligned significand of MAN_W bits.
module fpc_field_dec
  import fpc_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] bits_i,
  output fpc_unp_t       u_o
);

  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [EW-1:0] ef;
  logic [FW-1:0] fr;

  always_comb begin
    ef          = bits_i[EW+FW-1:FW];
    fr          = bits_i[FW-1:0];
    u_o.sign    = bits_i[EW+FW];
    u_o.is_nan  = (&ef) && (|fr);
    u_o.is_inf  = (&ef) && !(|fr);
    u_o.is_zero = !(|ef) && !(|fr);
    u_o.is_sub  = !(|ef) && (|fr);
    u_o.exp     = EXP_W'(ef) - EXP_W'(BIAS);
    u_o.mant    = MAN_W'({(|ef), fr}) << (MAN_W - 1 - FW);
  end

endmodule

// File: rtl/fpc_unpack.sv
// Selects the single or double decoder output by the precision bit.
module fpc_unpack
  import fpc_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            dbl_i,
  output fpc_unp_t        u_o
);

  fpc_unp_t u_sgl;
  fpc_unp_t u_dbl;

  fpc_field_dec #(.EW(SGL_EW), .FW(SGL_FW)) u_dec_sgl (
    .bits_i (op_i[SGL_EW+SGL_FW:0]),
    .u_o    (u_sgl)
  );

  fpc_field_dec #(.EW(DBL_EW), .FW(DBL_FW)) u_dec_dbl (
    .bits_i (op_i[DBL_EW+DBL_FW:0]),
    .u_o    (u_dbl)
  );

  always_comb begin
    u_o = dbl_i ? u_dbl : u_sgl;
  end

endmodule

// File: rtl/fpc_round.sv
// Aligns the significand to a fixed binary point, extracts integer part,
// guard and sticky, and applies the mode-dependent increment.
module fpc_round
  import fpc_pkg::*;
(
  input  fpc_unp_t         u_i,
  input  rmode_e           rm_i,
  output logic [INT_W:0]   mag_o,
  output logic             big_o
);

  localparam int PAD = INT_W + 2;
  localparam int VW  = MAN_W + PAD;
  localparam int SH0 = MAN_W - 2 + PAD;   // shift that leaves floor(2*|v|)

  logic [VW-1:0]    vec;
  logic [VW-1:0]    msk;
  logic [INT_W:0]   twice;
  logic [INT_W-1:0] ipart;
  logic             grd;
  logic             stk;
  logic             inc;
  int               shi;
  int               ex;

  always_comb begin
    vec   = {u_i.mant, {PAD{1'b0}}};
    ex    = int'(u_i.exp);
    shi   = SH0 - ex;
    big_o = 1'b0;
    twice = '0;
    msk   = '0;
    stk   = 1'b0;
    if (u_i.is_inf) begin
      big_o = 1'b1;
    end else if (u_i.is_nan || u_i.is_zero) begin
      stk = 1'b0;
    end else if (u_i.is_sub || ex < -1) begin
      stk = 1'b1;                          // 0 < |v| < 0.5
    end else if (ex >= INT_W) begin
      big_o = 1'b1;                        // |v| >= 2^INT_W
    end else begin
      twice = (INT_W+1)'(vec >> shi);
      msk   = ~({VW{1'b1}} << shi);
      stk   = |(vec & msk);
    end
    ipart = twice[INT_W:1];
    grd   = twice[0];
  end

  always_comb begin
    unique case (rm_i)
      RM_TIES_AWAY: inc = grd;
      RM_TIES_EVEN: inc = grd & (stk | ipart[0]);
      RM_UP:        inc = ~u_i.sign & (grd | stk);
      RM_DOWN:      inc = u_i.sign & (grd | stk);
      default:      inc = 1'b0;
    endcase
    mag_o = {1'b0, ipart} + (INT_W+1)'(inc);
  end

endmodule

// File: rtl/fpc_sat.sv
// Clamps the rounded magnitude to the signed or unsigned target range.
module fpc_sat
  import fpc_pkg::*;
(
  input  logic             sign_i,
  input  logic             nan_i,
  input  logic             big_i,
  input  logic [INT_W:0]   mag_i,
  input  logic             signed_i,
  output logic [INT_W-1:0] res_o
);

  localparam logic [INT_W:0]   POS_LIM = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   NEG_LIM = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] S_MAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN   = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] U_MAX   = {INT_W{1'b1}};

  always_comb begin
    if (nan_i) begin
      res_o = '0;
    end else if (signed_i) begin
      if (!sign_i) begin
        res_o = (big_i || mag_i > POS_LIM) ? S_MAX : mag_i[INT_W-1:0];
      end else begin
        res_o = (big_i || mag_i > NEG_LIM) ? S_MIN
                                           : (~mag_i[INT_W-1:0] + INT_W'(1));
      end
    end else begin
      if (sign_i) begin
        res_o = '0;
      end else begin
        res_o = (big_i || mag_i[INT_W]) ? U_MAX : mag_i[INT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/fp2int_conv.sv
module fp2int_conv
  import fpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_dbl,
  input  logic             in_signed,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result
);

  fpc_unp_t         unp;
  logic [INT_W:0]   mag;
  logic             big;
  logic [INT_W-1:0] sat_res;
  logic [INT_W-1:0] res_d;
  logic [INT_W-1:0] res_q;
  logic             vld_d;
  logic             vld_q;
  logic             res_en;

  fpc_unpack u_unpack (
    .op_i  (in_op),
    .dbl_i (in_dbl),
    .u_o   (unp)
  );

  fpc_round u_round (
    .u_i   (unp),
    .rm_i  (rmode_e'(in_rmode)),
    .mag_o (mag),
    .big_o (big)
  );

  fpc_sat u_sat (
    .sign_i   (unp.sign),
    .nan_i    (unp.is_nan),
    .big_i    (big),
    .mag_i    (mag),
    .signed_i (in_signed),
    .res_o    (sat_res)
  );

  // next state
  always_comb begin
    vld_d  = in_valid;
    res_en = in_valid;
    res_d  = sat_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk
  import fpc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OP_W-1:0]  in_op,
  input logic             in_dbl,
  input logic             in_signed,
  input logic             out_valid,
  input logic [INT_W-1:0] out_result
);

  logic op_nan;
  logic op_neg;
  logic op_pinf;

  always_comb begin
    if (in_dbl) begin
      op_nan  = (&in_op[62:52]) && (|in_op[51:0]);
      op_neg  = in_op[63];
      op_pinf = (in_op == 64'h7FF0_0000_0000_0000);
    end else begin
      op_nan  = (&in_op[30:23]) && (|in_op[22:0]);
      op_neg  = in_op[31];
      op_pinf = (in_op[31:0] == 32'h7F80_0000);
    end
  end

  // R11: result strobe one cycle after the operand strobe
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R12: result held while idle
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));

  // R8: NaN converts to zero
  a_r8_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_nan) |=> (out_result == '0));

  // R7: negative operand into unsigned target gives zero
  a_r7_unsigned_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_signed && op_neg) |=> (out_result == '0));

  // R9: plus infinity into signed target gives the positive limit
  a_r9_pinf_signed: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && op_pinf) |=> (out_result == 32'h7FFF_FFFF));

endmodule

bind fp2int_conv fpc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_dbl     (in_dbl),
  .in_signed  (in_signed),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/sim_fp2int_conv.sv
`timescale 1ns/1ps
module sim_fp2int_conv;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_op;
  logic        in_dbl;
  logic        in_signed;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [31:0] out_result;

  int n_chk;
  int n_bad;

  fp2int_conv u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_dbl     (in_dbl),
    .in_signed  (in_signed),
    .in_rmode   (in_rmode),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  // Reference: round in real arithmetic, then clamp.
  function automatic logic [31:0] ref_conv(real v, bit sg, bit [1:0] rm);
    real fl, er, r;
    fl = $floor(v);
    er = v - fl;
    r  = fl;
    case (rm)
      2'b00: if (er > 0.5 || (er == 0.5 && fl >= 0.0)) r = fl + 1.0;
      2'b01: if (er > 0.5 || (er == 0.5 && (longint'(fl) % 2 != 0))) r = fl + 1.0;
      2'b10: if (er > 0.0) r = fl + 1.0;
      default: r = fl;
    endcase
    if (sg) begin
      if (r >= 2147483647.0) return 32'h7FFF_FFFF;
      if (r < -2147483648.0) return 32'h8000_0000;
      return 32'(longint'(r));
    end else begin
      if (r >= 4294967295.0) return 32'hFFFF_FFFF;
      if (r < 0.0) return 32'h0;
      return 32'(longint'(r));
    end
  endfunction

  // Exact single-precision encoding for normal values representable in 24 bits.
  function automatic logic [31:0] to_sgl(real v);
    logic [63:0] d;
    d = $realtobits(v);
    if (v == 0.0) return {d[63], 31'h0};
    return {d[63], 8'(int'(d[62:52]) - 1023 + 127), d[51:29]};
  endfunction

  function automatic string mode_tag(bit [1:0] m);
    case (m)
      2'b00:   return "R1 ties-away";
      2'b01:   return "R2 ties-even";
      2'b10:   return "R3 ceiling";
      default: return "R4 floor";
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] expv, string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // One operation: drive at a falling edge, read at the next falling edge.
  task automatic run_op(logic [63:0] op, bit dbl, bit sg, bit [1:0] rm,
                        logic [31:0] expv, string tag);
    @(negedge clk);
    in_op     = op;
    in_dbl    = dbl;
    in_signed = sg;
    in_rmode  = rm;
    in_valid  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (out_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R11 valid latency (%s): actual %b expected 1", tag, out_valid);
    end
    check(out_result, expv, tag);
  endtask

  task automatic run_real(real v, bit dbl, string pre);
    logic [63:0] op;
    op = dbl ? $realtobits(v) : {32'hDEAD_BEEF, to_sgl(v)};   // R5 upper garbage
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        run_op(op, dbl, s[0], m[1:0], ref_conv(v, s[0], m[1:0]),
               $sformatf("%s %s sg=%0d v=%f", pre, mode_tag(m[1:0]), s, v));
  endtask

  task automatic run_fixed(logic [63:0] op, bit dbl, logic [31:0] e_s,
                           logic [31:0] e_u, string tag);
    for (int m = 0; m < 4; m++) begin
      run_op(op, dbl, 1'b1, m[1:0], e_s, tag);
      run_op(op, dbl, 1'b0, m[1:0], e_u, tag);
    end
  endtask

  real dbl_bnd [17] = '{2147483646.5, 2147483647.0, 2147483647.5, 2147483648.0,
                        -2147483648.0, -2147483648.5, -2147483649.0, 4294967294.5,
                        4294967295.0, 4294967295.5, 4294967296.0, 1.0e20, -1.0e20,
                        1.0e-300, -1.0e-300, 0.49999999, -0.5000001};
  real sgl_bnd [7]  = '{2147483648.0, 4294967296.0, 3221225472.0, -2147483648.0,
                        -2147483904.0, 8388607.5, -8388607.5};

  initial begin : watchdog
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    real v;
    logic [31:0] held;
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_op     = '0;
    in_dbl    = 1'b0;
    in_signed = 1'b0;
    in_rmode  = 2'b00;
    repeat (3) @(negedge clk);
    // R11: reset holds the strobe low
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: actual %b expected 0", out_valid);
    end
    rst_n = 1'b1;

    // Quarter-step sweep: R1..R4 modes, R5 both precisions, R6/R7 signedness
    for (int k = -40; k <= 40; k++) begin
      v = k / 4.0;
      run_real(v, 1'b1, "dbl");
      run_real(v, 1'b0, "R5 sgl");
    end

    // R6 / R7: range limits
    foreach (dbl_bnd[i]) run_real(dbl_bnd[i], 1'b1, "R6/R7 limit dbl");
    foreach (sgl_bnd[i]) run_real(sgl_bnd[i], 1'b0, "R5/R6/R7 limit sgl");

    // R10: small negatives and signed zeros
    run_real(-0.25, 1'b1, "R10 small-neg");
    run_real(-0.75, 1'b0, "R10 small-neg");
    run_fixed(64'h0000_0000_0000_0000, 1'b1, 32'h0, 32'h0, "R10 +0 dbl");
    run_fixed(64'h8000_0000_0000_0000, 1'b1, 32'h0, 32'h0, "R10 -0 dbl");
    run_fixed(64'hDEAD_BEEF_8000_0000, 1'b0, 32'h0, 32'h0, "R10 -0 sgl");

    // R3 / R4: subnormal single operands
    run_op(64'hDEAD_BEEF_0000_0001, 1'b0, 1'b1, 2'b10, 32'h1, "R3 subnormal ceiling");
    run_op(64'hDEAD_BEEF_8000_0001, 1'b0, 1'b1, 2'b11, 32'hFFFF_FFFF, "R4 subnormal floor");
    run_op(64'hDEAD_BEEF_8000_0001, 1'b0, 1'b0, 2'b11, 32'h0, "R10 subnormal unsigned");

    // R8: NaN
    run_fixed(64'h7FF8_0000_0000_0000, 1'b1, 32'h0, 32'h0, "R8 qNaN dbl");
    run_fixed(64'hFFF0_0000_0000_0001, 1'b1, 32'h0, 32'h0, "R8 sNaN dbl");
    run_fixed(64'hDEAD_BEEF_7FC0_0000, 1'b0, 32'h0, 32'h0, "R8 qNaN sgl");
    run_fixed(64'h0000_0000_FF80_0001, 1'b0, 32'h0, 32'h0, "R8 sNaN sgl");

    // R9: infinities
    run_fixed(64'h7FF0_0000_0000_0000, 1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9 +inf dbl");
    run_fixed(64'hFFF0_0000_0000_0000, 1'b1, 32'h8000_0000, 32'h0, "R9 -inf dbl");
    run_fixed(64'hDEAD_BEEF_7F80_0000, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9 +inf sgl");
    run_fixed(64'hDEAD_BEEF_FF80_0000, 1'b0, 32'h8000_0000, 32'h0, "R9 -inf sgl");

    // R12: result held while idle, other inputs changing
    run_op($realtobits(1234.5), 1'b1, 1'b1, 2'b01, 32'd1234, "R12 setup");
    held = 32'd1234;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_op     = $realtobits(-99.0 - i);
      in_signed = i[0];
      in_rmode  = i[1:0];
      n_chk++;
      if (out_valid !== 1'b0) begin
        n_bad++;
        $display("FAIL R11 idle strobe: actual %b expected 0", out_valid);
      end
      check(out_result, held, "R12 hold");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule